// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Enable Controller

This block lets a two-wire serial host switch ten buffered copies of one reference clock on and off. A write-only serial slave watches the oversampled clock and data lines. It recognises start and stop conditions and shifts in bytes most significant bit first. It acknowledges each byte it accepts by pulling the data line low for the ninth clock.

A transfer consists of the following bytes, in this order:
- one address byte;
- two bytes that are acknowledged and then discarded;
- up to ten data bytes, which fill the control bytes in order starting at byte 0.

The control bytes are never addressed individually, so a host that wants to change a later byte resends all the earlier ones.

Three of the control bytes decide which clock outputs run. A cleared bit holds its output low. Enable changes cross into the reference clock domain and take effect only while that clock is low, so no output shows a shortened pulse. A separate active-low pin turns off the drive enables of all ten outputs at once.

Top module: `clkfan_ctrl`

## Requirements
- R1: A falling data line while the serial clock is high starts a transfer, and a rising data line while the serial clock is high ends it. Bytes clocked while no transfer is open are never acknowledged.
- R2: Bytes are received most significant bit first. An accepted byte is acknowledged by asserting `sda_pull` (1 = drive the line low) during the ninth serial clock. `sda_pull` only rises while the serial clock is low.
- R3: Only the address byte value 0xD2 (device address 0x69, write) is acknowledged. Any other value, including the read form 0xD3, gets no acknowledge. The rest of that transfer gets no acknowledge and changes no state.
- R4: The two bytes that follow the address are always acknowledged, and their values change no control byte.
- R5: Data bytes are stored at control byte 0, 1, 2 and so on, in the order they arrive. Control bytes that a transfer does not reach keep their previous value.
- R6: At most ten data bytes are accepted per transfer. An eleventh byte and any later byte are not acknowledged and are not stored.
- R7: Output enables come from three control bytes:
  - byte 0 bits 3..0 drive outputs 3..0;
  - byte 1 bits 7..4 drive outputs 9..6;
  - byte 4 bit 7 drives output 5, and byte 4 bit 6 drives output 4.

  An enable of 1 passes the reference clock, and 0 holds the output low. All other bits have no effect on the outputs.
- R8: After reset, bytes 0 and 1 hold 0xFF, byte 4 holds 0xC0 and the other bytes hold 0x00. All ten outputs therefore run, and `sda_pull` is low.
- R9: While `oe_n` is low, every bit of `clk_oe` is 0 whatever the control bytes hold. While `oe_n` is high, every bit is 1.
- R10: A start condition in the middle of a transfer returns the slave to the address phase. The next byte is treated as an address, and data bytes then begin again at byte 0.
- R11: An enable change takes effect only while the reference clock is low. A clock output therefore rises only when the reference clock rises and falls only when it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high power-up reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| ref_clk | input | 1 | Reference clock to be distributed |
| oe_n | input | 1 | Active-low enable for the drivers of all clock outputs |
| sda_pull | output | 1 | 1 = pull the serial data line low (acknowledge) |
| clk_out | output | 10 | Gated copies of the reference clock |
| clk_oe | output | 10 | Drive enables of the clock outputs (0 = high impedance) |

## Verification
Most internal faults here appear as a missing or extra acknowledge on the wire in the same byte. A wrong phase, byte index or address compare shows up as a missing or extra `sda_pull` in the ninth clock of the affected byte. A wrong store or a wrong bit mapping does not appear on `sda_pull`. It appears on `clk_out` a few reference cycles after the transfer: one output stays low or keeps toggling against the expected enable pattern. A gating register sampled on the wrong edge shows up as an output edge that does not line up with a reference clock edge.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int NUM_OUT   = 10;
    localparam int NUM_BYTES = 10;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(NUM_BYTES + 1);
    localparam int BIT_W     = $clog2(BYTE_W + 2);
    localparam logic [BYTE_W-1:0] DEV_WORD = 8'hD2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NUM_BYTES-1:0][BYTE_W-1:0] bank_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        byte_t            data;
    } wr_req_t;

    function automatic byte_t reset_value(input int unsigned i);
        case (i)
            0, 1:    return 8'hFF;
            4:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NUM_OUT-1:0] enable_map(input bank_t bank);
        logic [NUM_OUT-1:0] en;
        en[3:0] = bank[0][3:0];
        en[9:6] = bank[1][7:4];
        en[5]   = bank[4][7];
        en[4]   = bank[4][6];
        return en;
    endfunction

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_ADDR: return PH_CMD;
            PH_CMD:  return PH_CNT;
            PH_CNT:  return PH_DATA;
            PH_DATA: return PH_DATA;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/clkfan_bus_sense.sv
module clkfan_bus_sense
    import clkfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
    logic scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[TOP-1:0], scl_i};
            sda_chain <= {sda_chain[TOP-1:0], sda_i};
            scl_prev  <= scl_chain[TOP];
            sda_prev  <= sda_chain[TOP];
        end
    end

    always_comb begin
        ev.sda   = sda_chain[TOP];
        ev.rise  = scl_chain[TOP] & ~scl_prev;
        ev.fall  = ~scl_chain[TOP] & scl_prev;
        ev.start = scl_chain[TOP] & scl_prev & sda_prev & ~sda_chain[TOP];
        ev.stop  = scl_chain[TOP] & scl_prev & ~sda_prev & sda_chain[TOP];
    end

endmodule

// File: rtl/clkfan_slave_fsm.sv
module clkfan_slave_fsm
    import clkfan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    scl_lvl,
    output logic    ack,
    output wr_req_t wr
);
    phase_e           phase;
    logic [BIT_W-1:0] bitcnt;
    byte_t            shreg;
    logic [IDX_W-1:0] idx;
    logic             accept;

    always_comb begin
        case (phase)
            PH_ADDR:         accept = (shreg == DEV_WORD);
            PH_CMD, PH_CNT:  accept = 1'b1;
            PH_DATA:         accept = (idx < IDX_W'(NUM_BYTES));
            default:         accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        wr.en <= 1'b0;
        if (rst) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            idx     <= '0;
            ack     <= 1'b0;
            wr.idx  <= '0;
            wr.data <= '0;
        end else if (ev.start) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            ack    <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            ack   <= 1'b0;
        end else if (phase != PH_IDLE && phase != PH_SKIP) begin
            if (ev.rise && bitcnt < BIT_W'(BYTE_W)) begin
                shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                bitcnt <= bitcnt + 1'b1;
            end else if (ev.fall && bitcnt == BIT_W'(BYTE_W)) begin
                if (accept) begin
                    ack    <= 1'b1;
                    bitcnt <= BIT_W'(BYTE_W + 1);
                    if (phase == PH_DATA) begin
                        wr.en   <= 1'b1;
                        wr.idx  <= idx;
                        wr.data <= shreg;
                    end
                end else begin
                    phase <= PH_SKIP;
                end
            end else if (ev.fall && bitcnt == BIT_W'(BYTE_W + 1)) begin
                ack    <= 1'b0;
                bitcnt <= '0;
                phase  <= next_phase(phase);
                if (phase == PH_DATA) idx <= idx + 1'b1;
            end
        end
    end

    // R2: the acknowledge is only ever raised while the serial clock is low
    assert_ack_rise_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> !scl_lvl);

    // R3: no acknowledge while the slave is ignoring the bus
    assert_no_ack_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !ack);

    // R10: a start condition always reopens the address phase
    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_ADDR && bitcnt == '0 && idx == '0));

    // R1: a stop condition drops any acknowledge
    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !ack);

endmodule

// File: rtl/clkfan_reg_bank.sv
module clkfan_reg_bank
    import clkfan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    output logic [NUM_OUT-1:0] enables
);
    bank_t bank;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= reset_value(g);
            else if (wr.en && wr.idx == IDX_W'(g))
                bank[g] <= wr.data;
        end

        // R5: a byte that is not being written keeps its value
        assert_byte_retained_R5: assert property (@(posedge clk) disable iff (rst)
            !(wr.en && wr.idx == IDX_W'(g)) |=> $stable(bank[g]));
    end

    assign enables = enable_map(bank);

    // R6: the sequencer never issues a write beyond the last control byte
    assert_write_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx < IDX_W'(NUM_BYTES)));

endmodule

// File: rtl/clkfan_out_gate.sv
module clkfan_out_gate
    import clkfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               rst,
    input  logic               oe_n,
    input  logic [NUM_OUT-1:0] en_req,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe
);
    localparam int TOP = SYNC_STAGES - 1;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        logic [SYNC_STAGES-1:0] chain;
        logic                   en_low;

        always_ff @(posedge ref_clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[TOP-1:0], en_req[g]};
        end

        always_ff @(negedge ref_clk) begin
            if (rst) en_low <= 1'b1;
            else     en_low <= chain[TOP];
        end

        assign clk_out[g] = ref_clk & en_low;
    end

    assign clk_oe = {NUM_OUT{oe_n}};

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               ref_clk,
    input  logic               oe_n,
    output logic               sda_pull,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe
);
    bus_ev_t            ev;
    wr_req_t            wr;
    logic [NUM_OUT-1:0] enables;
    logic               scl_lvl;

    clkfan_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign scl_lvl = scl_i;

    clkfan_slave_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .scl_lvl (scl_lvl),
        .ack     (sda_pull),
        .wr      (wr)
    );

    clkfan_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .enables (enables)
    );

    clkfan_out_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .ref_clk (ref_clk),
        .rst     (rst),
        .oe_n    (oe_n),
        .en_req  (enables),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );

endmodule

// File: tb/clkfan_ctrl_bench.sv
module clkfan_ctrl_bench;

    localparam time Q = 200ns;

    logic clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic oe_n = 1'b1;
    logic sda_pull;
    logic [9:0] clk_out, clk_oe;
    wire  sda_line = sda_m & ~sda_pull;

    always #5ns clk = ~clk;
    always #15ns ref_clk = ~ref_clk;

    clkfan_ctrl u_clkfan_ctrl (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .ref_clk  (ref_clk),
        .oe_n     (oe_n),
        .sda_pull (sda_pull),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    // scoreboard
    string tag_q[$];
    int    exp_q[$];
    int    act_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    event  item_ev;

    logic [7:0] mdl [10];
    logic [7:0] tx  [16];
    int glitch_cnt = 0;
    logic [9:0] prev_out = '0;

    task automatic push(input string tag, input int e, input int a);
        tag_q.push_back(tag);
        exp_q.push_back(e);
        act_q.push_back(a);
        -> item_ev;
    endtask

    task automatic drain();
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            string t = tag_q.pop_front();
            int e = exp_q.pop_front();
            int a = act_q.pop_front();
            n_cmp++;
            if (e != a) begin
                n_bad++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
            end
        end
    endtask

    initial begin
        forever begin
            @(item_ev);
            drain();
        end
    end

    // R11: output edges must line up with reference edges
    always @(clk_out) begin
        if (!rst) begin
            if (((clk_out & ~prev_out) != 0) && ref_clk !== 1'b1) glitch_cnt++;
            if (((~clk_out & prev_out) != 0) && ref_clk !== 1'b0) glitch_cnt++;
        end
        prev_out = clk_out;
    end

    function automatic int model_mask();
        logic [9:0] m;
        m[3:0] = mdl[0][3:0];
        m[9:6] = mdl[1][7:4];
        m[5]   = mdl[4][7];
        m[4]   = mdl[4][6];
        return int'(m);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = v[i]; #Q;
            scl = 1'b1;   #(2*Q);
            scl = 1'b0;   #Q;
        end
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        push(tag, int'(exp_ack), int'(!sda_line));
        #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic write_block(input int n, input string tag);
        bus_start();
        send_byte(8'hD2, 1'b1, {tag, " R3 address ack"});
        send_byte(8'h5A, 1'b1, {tag, " R4 command ack"});
        send_byte(8'h03, 1'b1, {tag, " R4 count ack"});
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], i < 10, {tag, " R6 data ack"});
            if (i < 10) mdl[i] = tx[i];
        end
        bus_stop();
    endtask

    task automatic check_outputs(input string tag);
        repeat (10) @(posedge ref_clk);
        #7ns;
        push({tag, " high phase"}, model_mask(), int'(clk_out));
        @(negedge ref_clk);
        #7ns;
        push({tag, " low phase"}, 0, int'(clk_out));
    endtask

    initial begin
        for (int i = 0; i < 10; i++)
            mdl[i] = (i < 2) ? 8'hFF : (i == 4 ? 8'hC0 : 8'h00);
        repeat (10) @(posedge clk);
        rst = 1'b0;
        #100ns;

        push("R8 sda_pull idle", 0, int'(sda_pull));
        push("R9 drivers on", 10'h3FF, int'(clk_oe));
        check_outputs("R8 reset outputs");

        // two data bytes, byte 4 retained
        tx[0] = 8'h05; tx[1] = 8'hA0;
        write_block(2, "T1");
        check_outputs("R5 R7 partial write");

        // only header bytes: nothing changes
        write_block(0, "T2");
        check_outputs("R4 header only");

        // full write plus an eleventh byte
        tx[0] = 8'hF0; tx[1] = 8'h0F; tx[2] = 8'hFF; tx[3] = 8'hFF;
        tx[4] = 8'h80;
        for (int i = 5; i < 11; i++) tx[i] = 8'hFF;
        write_block(11, "T3");
        check_outputs("R6 R7 full write");

        // foreign address and read request
        bus_start();
        send_byte(8'h90, 1'b0, "R3 foreign address");
        send_byte(8'h00, 1'b0, "R3 byte after foreign address");
        bus_stop();
        bus_start();
        send_byte(8'hD3, 1'b0, "R3 read request");
        send_byte(8'hFF, 1'b0, "R3 byte after read request");
        bus_stop();
        check_outputs("R3 no change");

        // bytes without a start condition
        scl = 1'b0; #Q;
        send_byte(8'hD2, 1'b0, "R1 no start");
        bus_stop();

        // repeated start mid-transfer
        bus_start();
        send_byte(8'hD2, 1'b1, "R10 first address");
        send_byte(8'h00, 1'b1, "R10 command");
        send_byte(8'h00, 1'b1, "R10 count");
        send_byte(8'h00, 1'b1, "R10 data before restart");
        mdl[0] = 8'h00;
        bus_start();
        send_byte(8'hD2, 1'b1, "R10 address after restart");
        send_byte(8'h11, 1'b1, "R10 command after restart");
        send_byte(8'h22, 1'b1, "R10 count after restart");
        send_byte(8'h0E, 1'b1, "R10 byte0 after restart");
        mdl[0] = 8'h0E;
        send_byte(8'hC0, 1'b1, "R10 byte1 after restart");
        mdl[1] = 8'hC0;
        bus_stop();
        check_outputs("R10 R7 restart result");

        // output enable pin
        oe_n = 1'b0; #40ns;
        push("R9 drivers off", 0, int'(clk_oe));
        oe_n = 1'b1; #40ns;
        push("R9 drivers back on", 10'h3FF, int'(clk_oe));

        push("R11 edge alignment", 0, glitch_cnt);

        #100ns;
        drain();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1500us;
        if (!done) begin
            done = 1'b1;
            drain();
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule